// File: doc/BRIEF.md
# Flash Erase Suspend/Resume Controller

This block is the operation state machine of a sectored NOR flash. It handles sector erase, chip erase, program, autoselect, erase suspend and erase resume. An upstream command decoder has already parsed the bus unlock cycles. It presents each recognised command to this block as a one-cycle strobe, together with the sector index that the write addressed. A free-running `tick` input is the time base for two delays: the collection window that follows a sector-erase command, and the suspend latency while an erase is actually running.

The block publishes a coded operation state and the mask of sectors selected for erase. The array sequencer uses both to decide whether to erase, program or pause. The status generator uses the same state to build its polling bits. The sequencer answers with `alg_done` when the current erase or program finishes. The block itself holds no array contents and no bus timing.

State codes on `op_state`: 0 array read, 1 autoselect, 2 program, 3 chip erase, 4 collection window, 5 erasing, 6 suspend pending, 7 erase suspended, 8 program while suspended, 9 autoselect while suspended.

Top module: `flash_erase_suspend_ctrl`

## Requirements
- R1: After reset `op_state` is 0, `erase_mask` is all zero and `prog_reject` is 0.
- R2: A sector-erase strobe in state 0 moves to state 4 on the next cycle and sets bit `sector` of `erase_mask`. Each further sector-erase strobe in state 4 sets its own bit and restarts the window count.
- R3: State 4 counts `tick` cycles from its last (re)start. Once WIN_TICKS ticks have been counted, the next cycle moves to state 5.
- R4: A suspend strobe in state 4 moves straight to state 7 on the next cycle, with no latency.
- R5: A suspend strobe in state 5 moves to state 6. Once LAT_TICKS ticks have been counted there, the next cycle moves to state 7, so it takes LAT_TICKS+1 cycles when a tick arrives every cycle.
- R6: A suspend strobe has no effect in states 0, 2 and 3, and has no effect on a suspend that is already in place.
- R7: A resume strobe in state 7 moves to state 5. In every other state it is ignored. A new suspend is accepted after resuming. Neither strobe looks at `sector`.
- R8: A program strobe in state 7 whose sector is not in `erase_mask` moves to state 8. `alg_done` in state 8 returns to state 7.
- R9: A program strobe in state 7 whose sector is in `erase_mask` raises `prog_reject` for one cycle, and the state stays 7.
- R10: Autoselect entry in state 7 goes to 9 and exit returns to 7. From state 0, entry goes to 1 and exit returns to 0.
- R11: `alg_done` in state 5 or 6 returns to state 0 and clears `erase_mask`. `alg_done` in state 2 or 3 returns to state 0.
- R12: Asserting reset during any operation returns to state 0 and clears `erase_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| tick | input | 1 | Time-base pulse for the window and latency counts |
| cmd_sector_erase | input | 1 | Sector-erase strobe |
| cmd_chip_erase | input | 1 | Chip-erase strobe |
| cmd_program | input | 1 | Program strobe |
| cmd_suspend | input | 1 | Erase-suspend strobe |
| cmd_resume | input | 1 | Erase-resume strobe |
| cmd_asel_enter | input | 1 | Autoselect entry strobe |
| cmd_asel_exit | input | 1 | Autoselect exit strobe |
| sector | input | SW | Sector index of the command write |
| alg_done | input | 1 | Array sequencer finished the current erase or program |
| op_state | output | 4 | Coded operation state |
| erase_mask | output | NSEC | Sectors selected for erase |
| prog_reject | output | 1 | One-cycle pulse: program to an erase-selected sector refused |
| suspended | output | 1 | High in states 7, 8 and 9 |

## Verification
The cases that are hardest to reach from the ports are the nested ones. A program or an autoselect entered while suspended must return to the suspended state, not to read. Reaching that needs an erase window, a suspend, and only then the inner command. Directed sequences build that chain with chosen sectors, so that both a hit and a miss on the erase mask are exercised. The zero-latency suspend inside the window and the bounded suspend during the running erase are timed cycle by cycle. After that, a long run of seeded random strobes, ticks, completions and occasional resets is compared each cycle against a bench model of the requirements.

// File: rtl/fesc_pkg.sv
package fesc_pkg;

    typedef enum logic [3:0] {
        S_READ      = 4'd0,
        S_ASEL      = 4'd1,
        S_PROGRAM   = 4'd2,
        S_CHIP      = 4'd3,
        S_WINDOW    = 4'd4,
        S_ERASING   = 4'd5,
        S_SUSP_PEND = 4'd6,
        S_SUSPENDED = 4'd7,
        S_SUSP_PROG = 4'd8,
        S_SUSP_ASEL = 4'd9
    } op_state_t;

    typedef struct packed {
        op_state_t st;
        logic      rej;
    } ctrl_regs_t;

endpackage

// File: rtl/fesc_tick_timer.sv
module fesc_tick_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = '0;
        else if (run && tick && (cnt_q != LIM))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LIM);

    // R3: a (re)start always brings the count back to zero
    p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == '0));

endmodule

// File: rtl/fesc_sector_mask.sv
module fesc_sector_mask #(
    parameter int NSEC = 8,
    localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            add_en,
    input  logic [SW-1:0]   add_idx,
    input  logic [SW-1:0]   probe_idx,
    output logic [NSEC-1:0] mask,
    output logic            probe_hit
);
    logic [NSEC-1:0] bits_d, bits_q;

    for (genvar g = 0; g < NSEC; g++) begin : g_bit
        always_comb begin
            bits_d[g] = bits_q[g];
            if (clear)
                bits_d[g] = 1'b0;
            else if (add_en && (add_idx == SW'(g)))
                bits_d[g] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign mask      = bits_q;
    assign probe_hit = bits_q[probe_idx];

    // R2: an add sets the addressed bit on the next cycle
    p_add_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !clear) |=> bits_q[$past(add_idx)]);

endmodule

// File: rtl/flash_erase_suspend_ctrl.sv
module flash_erase_suspend_ctrl
    import fesc_pkg::*;
#(
    parameter int NSEC      = 8,
    parameter int WIN_TICKS = 6,
    parameter int LAT_TICKS = 3,
    localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            cmd_sector_erase,
    input  logic            cmd_chip_erase,
    input  logic            cmd_program,
    input  logic            cmd_suspend,
    input  logic            cmd_resume,
    input  logic            cmd_asel_enter,
    input  logic            cmd_asel_exit,
    input  logic [SW-1:0]   sector,
    input  logic            alg_done,
    output logic [3:0]      op_state,
    output logic [NSEC-1:0] erase_mask,
    output logic            prog_reject,
    output logic            suspended
);
    ctrl_regs_t cur_q, nxt_d;
    logic win_start, lat_start, win_expired, lat_expired;
    logic mask_clr, mask_add, probe_hit;

    fesc_tick_timer #(.LIMIT(WIN_TICKS)) u_win (
        .clk(clk), .rst_n(rst_n), .start(win_start),
        .run(cur_q.st == S_WINDOW), .tick(tick), .expired(win_expired));

    fesc_tick_timer #(.LIMIT(LAT_TICKS)) u_lat (
        .clk(clk), .rst_n(rst_n), .start(lat_start),
        .run(cur_q.st == S_SUSP_PEND), .tick(tick), .expired(lat_expired));

    fesc_sector_mask #(.NSEC(NSEC)) u_mask (
        .clk(clk), .rst_n(rst_n), .clear(mask_clr), .add_en(mask_add),
        .add_idx(sector), .probe_idx(sector), .mask(erase_mask),
        .probe_hit(probe_hit));

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.rej = 1'b0;
        win_start = 1'b0;
        lat_start = 1'b0;
        mask_clr  = 1'b0;
        mask_add  = 1'b0;
        case (cur_q.st)
            S_READ: begin
                if (cmd_sector_erase) begin
                    nxt_d.st  = S_WINDOW;
                    mask_add  = 1'b1;
                    win_start = 1'b1;
                end else if (cmd_chip_erase) nxt_d.st = S_CHIP;
                else if (cmd_program)        nxt_d.st = S_PROGRAM;
                else if (cmd_asel_enter)     nxt_d.st = S_ASEL;
            end
            S_ASEL:            if (cmd_asel_exit) nxt_d.st = S_READ;
            S_PROGRAM, S_CHIP: if (alg_done)      nxt_d.st = S_READ;
            S_WINDOW: begin
                if (cmd_suspend) nxt_d.st = S_SUSPENDED;
                else if (cmd_sector_erase) begin
                    mask_add  = 1'b1;
                    win_start = 1'b1;
                end else if (win_expired) nxt_d.st = S_ERASING;
            end
            S_ERASING: begin
                if (alg_done) begin
                    nxt_d.st = S_READ;
                    mask_clr = 1'b1;
                end else if (cmd_suspend) begin
                    nxt_d.st  = S_SUSP_PEND;
                    lat_start = 1'b1;
                end
            end
            S_SUSP_PEND: begin
                if (alg_done) begin
                    nxt_d.st = S_READ;
                    mask_clr = 1'b1;
                end else if (lat_expired) nxt_d.st = S_SUSPENDED;
            end
            S_SUSPENDED: begin
                if (cmd_program) begin
                    if (probe_hit) nxt_d.rej = 1'b1;
                    else           nxt_d.st  = S_SUSP_PROG;
                end else if (cmd_asel_enter) nxt_d.st = S_SUSP_ASEL;
                else if (cmd_resume)         nxt_d.st = S_ERASING;
            end
            S_SUSP_PROG: if (alg_done)      nxt_d.st = S_SUSPENDED;
            S_SUSP_ASEL: if (cmd_asel_exit) nxt_d.st = S_SUSPENDED;
            default:     nxt_d.st = S_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: S_READ, rej: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign op_state    = cur_q.st;
    assign prog_reject = cur_q.rej;
    assign suspended   = (cur_q.st == S_SUSPENDED) || (cur_q.st == S_SUSP_PROG)
                      || (cur_q.st == S_SUSP_ASEL);

    // R4: suspend inside the collection window takes effect at once
    p_window_suspend_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == S_WINDOW && cmd_suspend) |=> (cur_q.st == S_SUSPENDED));

    // R5: once the latency count is reached the suspend completes next cycle
    p_latency_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == S_SUSP_PEND && lat_expired && !alg_done) |=> (cur_q.st == S_SUSPENDED));

    // R6: suspend during chip erase never leads into a suspend state
    p_chip_no_suspend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == S_CHIP && cmd_suspend) |=> !suspended && (cur_q.st != S_SUSP_PEND));

    // R7: resume from the suspended state continues the erase
    p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == S_SUSPENDED && cmd_resume && !cmd_program && !cmd_asel_enter)
        |=> (cur_q.st == S_ERASING));

    // R9: a refused program leaves the erase suspended
    p_reject_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_reject |-> (cur_q.st == S_SUSPENDED));

    // R11: erase completion returns to read with an empty mask
    p_done_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == S_ERASING && alg_done) |=> (cur_q.st == S_READ && erase_mask == '0));

endmodule

// File: tb/flash_erase_suspend_ctrl_test.sv
module flash_erase_suspend_ctrl_test;
    localparam int NSEC = 8;
    localparam int WIN  = 6;
    localparam int LAT  = 3;
    localparam int SW   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic c_se = 1'b0, c_ce = 1'b0, c_pg = 1'b0, c_sus = 1'b0;
    logic c_res = 1'b0, c_aen = 1'b0, c_aex = 1'b0;
    logic [SW-1:0] sector = '0;
    logic alg_done = 1'b0;
    logic [3:0] op_state;
    logic [NSEC-1:0] erase_mask;
    logic prog_reject, suspended;

    int n_checks = 0, n_fail = 0;
    bit done_flag = 1'b0;

    // bench model of the requirements
    int m_st = 0, m_wcnt = 0, m_lcnt = 0;
    logic [NSEC-1:0] m_mask = '0;
    bit m_rej = 1'b0;

    always #10 clk = ~clk;

    flash_erase_suspend_ctrl #(.NSEC(NSEC), .WIN_TICKS(WIN), .LAT_TICKS(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cmd_sector_erase(c_se), .cmd_chip_erase(c_ce), .cmd_program(c_pg),
        .cmd_suspend(c_sus), .cmd_resume(c_res), .cmd_asel_enter(c_aen),
        .cmd_asel_exit(c_aex), .sector(sector), .alg_done(alg_done),
        .op_state(op_state), .erase_mask(erase_mask),
        .prog_reject(prog_reject), .suspended(suspended));

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic bit is_susp(int s);
        return (s == 7) || (s == 8) || (s == 9);
    endfunction

    // cmd: 0 none, 1 sector erase, 2 chip erase, 3 program, 4 suspend,
    //      5 resume, 6 autoselect enter, 7 autoselect exit
    task automatic model_update(bit rst, int cmd, int sec, bit dn, bit tk);
        int ns = m_st;
        m_rej = 1'b0;
        if (rst) begin
            m_st = 0; m_mask = '0; m_wcnt = 0; m_lcnt = 0;
            return;
        end
        case (m_st)
            0: if (cmd == 1) begin ns = 4; m_mask[sec] = 1'b1; m_wcnt = 0; end
               else if (cmd == 2) ns = 3;
               else if (cmd == 3) ns = 2;
               else if (cmd == 6) ns = 1;
            1: if (cmd == 7) ns = 0;
            2, 3: if (dn) ns = 0;
            4: if (cmd == 4) ns = 7;
               else if (cmd == 1) begin m_mask[sec] = 1'b1; m_wcnt = 0; end
               else if (m_wcnt == WIN) ns = 5;
               else if (tk) m_wcnt++;
            5: if (dn) begin ns = 0; m_mask = '0; end
               else if (cmd == 4) begin ns = 6; m_lcnt = 0; end
            6: if (dn) begin ns = 0; m_mask = '0; end
               else if (m_lcnt == LAT) ns = 7;
               else if (tk) m_lcnt++;
            7: if (cmd == 3) begin
                   if (m_mask[sec]) m_rej = 1'b1; else ns = 8;
               end else if (cmd == 6) ns = 9;
               else if (cmd == 5) ns = 5;
            8: if (dn) ns = 7;
            9: if (cmd == 7) ns = 7;
            default: ns = 0;
        endcase
        m_st = ns;
    endtask

    task automatic step(string req, int cmd, int sec = 0, bit dn = 0, bit tk = 1, bit rst = 0);
        rst_n    = !rst;
        c_se = (cmd == 1); c_ce = (cmd == 2); c_pg = (cmd == 3); c_sus = (cmd == 4);
        c_res = (cmd == 5); c_aen = (cmd == 6); c_aex = (cmd == 7);
        sector   = SW'(sec);
        alg_done = dn;
        tick     = tk;
        model_update(rst, cmd, sec, dn, tk);
        @(negedge clk);
        check({req, " state"}, 32'(op_state), 32'(m_st));
        check({req, " mask"}, 32'(erase_mask), 32'(m_mask));
        check({req, " reject"}, 32'(prog_reject), 32'(m_rej));
        check({req, " suspended"}, 32'(suspended), 32'(is_susp(m_st)));
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        step("R1 reset", 0, 0, 0, 1, 1);
        check("R1 reset state", 32'(op_state), 32'd0);
        check("R1 reset mask", 32'(erase_mask), 32'd0);

        // R2 / R3: window collection and expiry
        step("R2 first sector", 1, 2);
        check("R2 window entered", 32'(op_state), 32'd4);
        step("R2 second sector", 1, 5);
        check("R2 mask two bits", 32'(erase_mask), 32'h24);
        for (int i = 0; i < WIN; i++) step("R3 window counting", 0);
        check("R3 still in window", 32'(op_state), 32'd4);
        step("R3 window ends", 0);
        check("R3 erase started", 32'(op_state), 32'd5);

        // R5: bounded suspend latency
        step("R5 suspend while erasing", 4, 6);
        for (int i = 0; i < LAT; i++) step("R5 pending", 0);
        check("R5 not yet suspended", 32'(op_state), 32'd6);
        step("R5 latency reached", 0);
        check("R5 suspended", 32'(op_state), 32'd7);

        // R9 / R8 / R10 nested operations
        step("R9 program to erasing sector", 3, 5);
        check("R9 reject pulse", 32'(prog_reject), 32'd1);
        check("R9 stays suspended", 32'(op_state), 32'd7);
        step("R8 program other sector", 3, 1);
        check("R8 program while suspended", 32'(op_state), 32'd8);
        step("R8 program done", 0, 0, 1);
        check("R8 back to suspended", 32'(op_state), 32'd7);
        step("R10 autoselect in suspend", 6);
        check("R10 nested autoselect", 32'(op_state), 32'd9);
        step("R10 autoselect exit", 7);
        check("R10 returns to suspended", 32'(op_state), 32'd7);

        // R7 resume, extra resume, new suspend
        step("R7 resume", 5, 7);
        check("R7 erasing again", 32'(op_state), 32'd5);
        step("R7 extra resume ignored", 5, 3);
        check("R7 extra resume", 32'(op_state), 32'd5);
        step("R7 suspend again", 4);
        check("R7 suspend after resume", 32'(op_state), 32'd6);
        step("R11 erase done while pending", 0, 0, 1);
        check("R11 read after done", 32'(op_state), 32'd0);
        check("R11 mask cleared", 32'(erase_mask), 32'd0);

        // R4 immediate suspend, R12 reset mid-operation
        step("R4 sector erase", 1, 3);
        step("R4 suspend in window", 4);
        check("R4 zero latency", 32'(op_state), 32'd7);
        step("R12 reset while suspended", 0, 0, 0, 1, 1);
        check("R12 state", 32'(op_state), 32'd0);
        check("R12 mask", 32'(erase_mask), 32'd0);
        step("R12 release", 0);

        // R6 ignored suspends, R10 plain autoselect
        step("R6 chip erase", 2);
        step("R6 suspend in chip erase", 4);
        check("R6 chip erase continues", 32'(op_state), 32'd3);
        step("R11 chip done", 0, 0, 1);
        step("R6 program", 3, 4);
        step("R6 suspend in program", 4);
        check("R6 program continues", 32'(op_state), 32'd2);
        step("R11 program done", 0, 0, 1);
        step("R6 suspend in read", 4);
        check("R6 read unchanged", 32'(op_state), 32'd0);
        step("R10 autoselect", 6);
        check("R10 autoselect state", 32'(op_state), 32'd1);
        step("R10 exit", 7);
        check("R10 back to read", 32'(op_state), 32'd0);

        // random mix compared against the model
        for (int i = 0; i < 4000; i++) begin
            int r   = int'($urandom % 16);
            int cmd = (r > 7) ? 0 : r;
            step("R2-model random", cmd, int'($urandom % NSEC),
                 ($urandom % 8) == 0, ($urandom % 4) != 0, ($urandom % 250) == 0);
        end
        finish_run();
    end
endmodule